// File: doc/BRIEF.md
# Masked Control Register File

This block keeps a bank of 64-bit internal control registers for a processor core. Each register is selected by a 6-bit index. On a write, a mask or a side effect that belongs to that register is applied. Some registers keep only a few bits. Some clear to zero on any write. Two of them emit a one-cycle flush pulse toward an external translation buffer. Reads follow per-register rules: some registers may not be read at all, one register merges a live cycle count into its low half, and one clears an interrupt-lock flag when it is read. Any write to a read-only register raises a one-cycle access fault, and so does any read of a write-only register or any use of an undefined index.

The control logic drives an index with a read strobe, a write strobe, or both in the same cycle. Results come back one clock later: the read data, the fault flag and the flush pulses. The lock flag is set by a dedicated input. A handler reads the faulting-address register to release the lock.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every register holds zero, except index 8 (base), which holds parameter BASE_RST, and index 24 (machine control), which holds MCTL_RST (default 0x6). intr_lock, rd_data, acc_fault and both flush outputs are 0.
- R2: A write at edge t is visible to a read issued from cycle t on. rd_data shows the read value in the cycle after rd_en and is zero in the cycle after any cycle without rd_en. A read and a write in the same cycle return the value from before the write.
- R3: The write masks are as follows. Index 10 and 11 keep bits 3:0. Index 12 keeps bits 4:0. Index 13 and 14 keep 0x18. Index 15 keeps 0x7fff0. Index 16 and 17 keep 0xffffffffc0000000. Index 18 and 19 keep bits 5:0. Index 20 keeps 0x1ffb. Index 21 keeps 0x7f0.
- R4: A write to index 9 (restart address) stores the data with bit 1 forced to zero.
- R5: Any write to index 22 or 23 (exception summary and mask) leaves it zero, whatever the data.
- R6: A read of index 25 returns the stored bits 63:32 joined with cyc_i[31:0] as sampled in the read cycle. A write to index 25 stores all 64 bits.
- R7: lock_set high at an edge makes intr_lock 1 after that edge. A read of index 26 without lock_set makes intr_lock 0 after that edge. When both happen in the same cycle, set wins.
- R8: A write to index 28 pulses flush_ixlat, and a write to index 29 pulses flush_dxlat. Each pulse lasts one cycle and appears in the cycle after the write.
- R9: acc_fault is 1 in the cycle after one of these accesses: a write to index 26, 27 or 30..63, or a read of index 20, 21, 28, 29 or 30..63. A faulting read returns zero. A faulting write changes no register.
- R10: Indices 0..7 (scratch), 8 and 24 store the full 64-bit write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 6 | Register index for this cycle's access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| cyc_i | input | 64 | Free-running cycle count |
| lock_set | input | 1 | Sets the interrupt-lock flag |
| rd_data | output | 64 | Read result, one cycle after rd_en |
| acc_fault | output | 1 | Access fault, one cycle after the access |
| flush_ixlat | output | 1 | Instruction translation flush-all pulse |
| flush_dxlat | output | 1 | Data translation flush-all pulse |
| intr_lock | output | 1 | Interrupt-lock flag |

## Verification
The hardest situations to reach from the ports are the ones where two actions hit in the same cycle. One is a lock set together with the clearing read. The other is a read and a write to the same register, where the read must return the old value. The driver gives each of these its own vector. Around them, it sweeps all 64 indices with an all-ones pattern and a mixed pattern, each written and then read back. That sweep reaches every mask, every clear-on-write register, every fault class and the undefined range in both directions. It also checks that a faulting write leaves the register unchanged.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int XLEN  = 64;
  localparam int IDX_W = 6;
  localparam int SCR_N = 8;

  localparam logic [IDX_W-1:0] RI_BASE    = IDX_W'(SCR_N + 0);
  localparam logic [IDX_W-1:0] RI_RESTART = IDX_W'(SCR_N + 1);
  localparam logic [IDX_W-1:0] RI_TRAPREQ = IDX_W'(SCR_N + 2);
  localparam logic [IDX_W-1:0] RI_TRAPEN  = IDX_W'(SCR_N + 3);
  localparam logic [IDX_W-1:0] RI_LEVEL   = IDX_W'(SCR_N + 4);
  localparam logic [IDX_W-1:0] RI_MODE_I  = IDX_W'(SCR_N + 5);
  localparam logic [IDX_W-1:0] RI_MODE_D  = IDX_W'(SCR_N + 6);
  localparam logic [IDX_W-1:0] RI_SWREQ   = IDX_W'(SCR_N + 7);
  localparam logic [IDX_W-1:0] RI_PTB_I   = IDX_W'(SCR_N + 8);
  localparam logic [IDX_W-1:0] RI_PTB_D   = IDX_W'(SCR_N + 9);
  localparam logic [IDX_W-1:0] RI_CMODE   = IDX_W'(SCR_N + 10);
  localparam logic [IDX_W-1:0] RI_QMODE   = IDX_W'(SCR_N + 11);
  localparam logic [IDX_W-1:0] RI_DCTEST  = IDX_W'(SCR_N + 12);
  localparam logic [IDX_W-1:0] RI_IASN    = IDX_W'(SCR_N + 13);
  localparam logic [IDX_W-1:0] RI_EXCSUM  = IDX_W'(SCR_N + 14);
  localparam logic [IDX_W-1:0] RI_EXCMSK  = IDX_W'(SCR_N + 15);
  localparam logic [IDX_W-1:0] RI_MCTL    = IDX_W'(SCR_N + 16);
  localparam logic [IDX_W-1:0] RI_CYC     = IDX_W'(SCR_N + 17);
  localparam logic [IDX_W-1:0] RI_FVA     = IDX_W'(SCR_N + 18);
  localparam logic [IDX_W-1:0] RI_INTID   = IDX_W'(SCR_N + 19);
  localparam logic [IDX_W-1:0] RI_FLI     = IDX_W'(SCR_N + 20);
  localparam logic [IDX_W-1:0] RI_FLD     = IDX_W'(SCR_N + 21);
  localparam int               NREG       = int'(RI_FLD) + 1;

  // bits kept by a legal write; zero mask means the register clears
  function automatic logic [XLEN-1:0] keep_mask(logic [IDX_W-1:0] i);
    case (i)
      RI_RESTART:             keep_mask = ~(XLEN'(2));
      RI_TRAPREQ, RI_TRAPEN:  keep_mask = XLEN'(64'hf);
      RI_LEVEL:               keep_mask = XLEN'(64'h1f);
      RI_MODE_I, RI_MODE_D:   keep_mask = XLEN'(64'h18);
      RI_SWREQ:               keep_mask = XLEN'(64'h7fff0);
      RI_PTB_I, RI_PTB_D:     keep_mask = XLEN'(64'hffff_ffff_c000_0000);
      RI_CMODE, RI_QMODE:     keep_mask = XLEN'(64'h3f);
      RI_DCTEST:              keep_mask = XLEN'(64'h1ffb);
      RI_IASN:                keep_mask = XLEN'(64'h7f0);
      RI_EXCSUM, RI_EXCMSK,
      RI_FLI, RI_FLD:         keep_mask = '0;
      default:                keep_mask = '1;
    endcase
  endfunction

  function automatic logic may_write(logic [IDX_W-1:0] i);
    may_write = (int'(i) < NREG) && (i != RI_FVA) && (i != RI_INTID);
  endfunction

  function automatic logic may_read(logic [IDX_W-1:0] i);
    may_read = (int'(i) < NREG) && (i != RI_DCTEST) && (i != RI_IASN) &&
               (i != RI_FLI) && (i != RI_FLD);
  endfunction
endpackage

// File: rtl/ctlreg_wpath.sv
module ctlreg_wpath
  import ctlreg_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  wdata,
  output logic             do_store,
  output logic [XLEN-1:0]  store_val,
  output logic             wr_fault,
  output logic             fl_i,
  output logic             fl_d
);
  always_comb begin
    do_store  = wr_en && may_write(idx);
    wr_fault  = wr_en && !may_write(idx);
    store_val = wdata & keep_mask(idx);
    fl_i      = do_store && (idx == RI_FLI);
    fl_d      = do_store && (idx == RI_FLD);
  end
endmodule

// File: rtl/ctlreg_rpath.sv
module ctlreg_rpath
  import ctlreg_pkg::*;
(
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  file_w [NREG],
  input  logic [XLEN-1:0]  cyc,
  output logic [XLEN-1:0]  rd_val,
  output logic             rd_fault,
  output logic             lock_clr
);
  localparam int SEL_W = $clog2(NREG);
  logic [SEL_W-1:0] sel;
  logic [XLEN-1:0]  raw;

  always_comb begin
    sel      = idx[SEL_W-1:0];
    raw      = (int'(sel) < NREG) ? file_w[sel] : '0;
    rd_fault = rd_en && !may_read(idx);
    lock_clr = rd_en && (idx == RI_FVA);
    rd_val   = '0;
    if (rd_en && may_read(idx)) begin
      if (idx == RI_CYC) rd_val = {raw[XLEN-1:32], cyc[31:0]};
      else               rd_val = raw;
    end
  end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter logic [63:0] BASE_RST = 64'h0000_0000_0001_0000,
  parameter logic [63:0] MCTL_RST = 64'h6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       reg_idx,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic             rd_en,
  input  logic [63:0]      cyc_i,
  input  logic             lock_set,
  output logic [63:0]      rd_data,
  output logic             acc_fault,
  output logic             flush_ixlat,
  output logic             flush_dxlat,
  output logic             intr_lock
);
  logic [XLEN-1:0] file_w [NREG];
  logic            do_store, wr_fault_w, rd_fault_w, lock_clr_w, fl_i_w, fl_d_w;
  logic [XLEN-1:0] store_val, rd_val;

  ctlreg_wpath u_wp (
    .wr_en(wr_en), .idx(reg_idx), .wdata(wr_data), .do_store(do_store),
    .store_val(store_val), .wr_fault(wr_fault_w), .fl_i(fl_i_w), .fl_d(fl_d_w)
  );

  ctlreg_rpath u_rp (
    .rd_en(rd_en), .idx(reg_idx), .file_w(file_w), .cyc(cyc_i),
    .rd_val(rd_val), .rd_fault(rd_fault_w), .lock_clr(lock_clr_w)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [XLEN-1:0] RV = (g == int'(RI_BASE)) ? BASE_RST :
                                     (g == int'(RI_MCTL)) ? MCTL_RST : '0;
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q <= RV;
      else if (do_store && (reg_idx == IDX_W'(g)))     q <= store_val;
    end
    assign file_w[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      acc_fault   <= 1'b0;
      flush_ixlat <= 1'b0;
      flush_dxlat <= 1'b0;
      intr_lock   <= 1'b0;
    end else begin
      rd_data     <= rd_val;
      acc_fault   <= wr_fault_w | rd_fault_w;
      flush_ixlat <= fl_i_w;
      flush_dxlat <= fl_d_w;
      if (lock_set)        intr_lock <= 1'b1;
      else if (lock_clr_w) intr_lock <= 1'b0;
    end
  end
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
  import ctlreg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  reg_idx,
  input logic        wr_en,
  input logic        rd_en,
  input logic [63:0] cyc_i,
  input logic        lock_set,
  input logic [63:0] rd_data,
  input logic        acc_fault,
  input logic        flush_ixlat,
  input logic        flush_dxlat,
  input logic        intr_lock,
  input logic        wr_fault_w
);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  p_cyc_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == RI_CYC) |=> rd_data[31:0] == $past(cyc_i[31:0]));
  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> intr_lock);
  p_lock_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == RI_FVA && !lock_set) |=> !intr_lock);
  p_flush_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ixlat |-> $past(wr_en && reg_idx == RI_FLI));
  p_flush_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_dxlat |-> $past(wr_en && reg_idx == RI_FLD));
  p_fault_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> $past(wr_en || rd_en));
  p_wfault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault_w |=> acc_fault);
endmodule

bind ctlreg_file ctlreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
  .cyc_i(cyc_i), .lock_set(lock_set), .rd_data(rd_data), .acc_fault(acc_fault),
  .flush_ixlat(flush_ixlat), .flush_dxlat(flush_dxlat), .intr_lock(intr_lock),
  .wr_fault_w(wr_fault_w)
);

// File: tb/sim_ctlreg_file.sv
`timescale 1ns/1ps
module sim_ctlreg_file;
  localparam logic [63:0] BASE = 64'h0000_0000_0001_0000;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] MIX  = 64'hA5C3_0F96_3C5A_E187;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] reg_idx = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, lock_set = 1'b0;
  logic [63:0] wr_data = '0, cyc_i = 64'h1234_5678_0000_0000;
  logic [63:0] rd_data;
  logic acc_fault, flush_ixlat, flush_dxlat, intr_lock;

  always #2 clk = ~clk;

  ctlreg_file u0 (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .cyc_i(cyc_i), .lock_set(lock_set), .rd_data(rd_data),
    .acc_fault(acc_fault), .flush_ixlat(flush_ixlat), .flush_dxlat(flush_dxlat),
    .intr_lock(intr_lock)
  );

  typedef struct {
    logic [63:0] rd;
    bit flt, fi, fd, lk;
    string tag;
  } exp_t;
  exp_t sb[$];

  int n_vec = 0, n_bad = 0;
  logic [63:0] m [64];
  bit mlk = 0;

  function automatic logic [63:0] kept(int ix, logic [63:0] d);
    case (ix)
      9:            return d & ~64'd2;
      10, 11:       return {60'b0, d[3:0]};
      12:           return {59'b0, d[4:0]};
      13, 14:       return {59'b0, d[4:3], 3'b0};
      15:           return {45'b0, d[18:4], 4'b0};
      16, 17:       return {d[63:30], 30'b0};
      18, 19:       return {58'b0, d[5:0]};
      20:           return d & 64'h1ffb;
      21:           return {53'b0, d[10:4], 4'b0};
      22, 23, 28, 29: return 64'd0;
      default:      return d;
    endcase
  endfunction

  task automatic op(bit rd, bit wr, int ix, logic [63:0] d, bit ls, string tag);
    exp_t e;
    bit rok, wok;
    @(negedge clk);
    cyc_i    = cyc_i + 64'h0000_0001_0000_0013;
    reg_idx  = 6'(ix);
    rd_en    = rd;
    wr_en    = wr;
    wr_data  = d;
    lock_set = ls;
    rok = !(ix >= 30 || ix == 20 || ix == 21 || ix == 28 || ix == 29);
    wok = !(ix >= 30 || ix == 26 || ix == 27);
    e.rd  = (rd && rok) ? ((ix == 25) ? {m[25][63:32], cyc_i[31:0]} : m[ix]) : 64'd0;
    e.flt = (rd && !rok) || (wr && !wok);
    e.fi  = wr && ix == 28;
    e.fd  = wr && ix == 29;
    if (ls) mlk = 1;
    else if (rd && ix == 26) mlk = 0;
    e.lk  = mlk;
    e.tag = tag;
    if (wr && wok) m[ix] = kept(ix, d);
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (rd_data !== e.rd || acc_fault !== e.flt || flush_ixlat !== e.fi ||
          flush_dxlat !== e.fd || intr_lock !== e.lk) begin
        n_bad++;
        $display("FAIL %s: rd=%h flt=%b fi=%b fd=%b lk=%b expected rd=%h flt=%b fi=%b fd=%b lk=%b",
                 e.tag, rd_data, acc_fault, flush_ixlat, flush_dxlat, intr_lock,
                 e.rd, e.flt, e.fi, e.fd, e.lk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
    m[8]  = BASE;
    m[24] = 64'h6;
    repeat (3) @(negedge clk);
    n_vec++;
    if (rd_data !== '0 || acc_fault !== 1'b0 || intr_lock !== 1'b0 ||
        flush_ixlat !== 1'b0 || flush_dxlat !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: rd=%h flt=%b lk=%b expected all zero", rd_data, acc_fault, intr_lock);
    end
    rst_n = 1'b1;

    op(1, 0, 8,  0, 0, "R1 base reset");
    op(1, 0, 24, 0, 0, "R1 machine control reset");
    op(1, 0, 0,  0, 0, "R1 scratch reset");
    op(1, 0, 12, 0, 0, "R1 level reset");
    op(0, 0, 0,  0, 0, "R2 idle zero");

    for (int i = 0; i < 8; i++) op(0, 1, i, MIX ^ 64'(i), 0, "R10 scratch write");
    for (int i = 0; i < 8; i++) op(1, 0, i, 0, 0, "R10 R2 scratch read");
    op(0, 1, 8,  ONES, 0, "R10 base write");
    op(1, 0, 8,  0, 0, "R10 base read");
    op(0, 1, 24, MIX, 0, "R10 machine control write");
    op(1, 0, 24, 0, 0, "R10 machine control read");

    op(1, 1, 3, 64'hDEAD_BEEF_0000_1111, 0, "R2 same-cycle read returns old");
    op(1, 0, 3, 0, 0, "R2 write visible next");

    for (int i = 0; i < 64; i++) begin
      op(0, 1, i, ONES, 0, $sformatf("R3 R4 R5 R9 sweep ones write %0d", i));
      op(1, 0, i, 0, 0, $sformatf("R3 R4 R5 R9 sweep ones read %0d", i));
      op(0, 1, i, MIX, 0, $sformatf("R3 R4 R5 R9 sweep mix write %0d", i));
      op(1, 0, i, 0, 0, $sformatf("R3 R4 R5 R9 sweep mix read %0d", i));
    end

    op(0, 1, 9, 64'h0000_0000_0000_0006, 0, "R4 restart bit1");
    op(1, 0, 9, 0, 0, "R4 restart bit1 read");

    op(0, 1, 25, 64'hFEDC_BA98_7654_3210, 0, "R6 cycle write");
    op(1, 0, 25, 0, 0, "R6 cycle read merge");
    op(1, 0, 25, 0, 0, "R6 cycle read live low");

    op(0, 0, 0, 0, 1, "R7 lock set");
    op(0, 0, 0, 0, 0, "R7 lock holds");
    op(1, 0, 26, 0, 0, "R7 read clears lock");
    op(0, 0, 0, 0, 1, "R7 lock set again");
    op(1, 0, 26, 0, 1, "R7 set wins over clearing read");
    op(1, 0, 26, 0, 0, "R7 clearing read");

    op(0, 1, 28, ONES, 0, "R8 flush instr");
    op(0, 1, 29, ONES, 0, "R8 flush data");
    op(0, 1, 28, 0, 0, "R8 flush instr again");
    op(0, 0, 0, 0, 0, "R8 pulse ends");

    op(0, 1, 27, ONES, 0, "R9 write read-only faults");
    op(1, 0, 27, 0, 0, "R9 read-only unchanged");
    op(0, 1, 26, ONES, 0, "R9 write fault-address faults");
    op(1, 0, 26, 0, 0, "R9 fault-address unchanged");
    op(1, 1, 45, MIX, 0, "R9 undefined both fault");
    op(1, 0, 20, 0, 0, "R9 write-only read faults");
    op(0, 1, 22, MIX, 0, "R5 clear on write");
    op(1, 0, 22, 0, 0, "R5 summary reads zero");
    op(0, 0, 0, 0, 0, "R2 final idle");

    @(negedge clk);
    rd_en = 0; wr_en = 0; lock_set = 0;
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule